// File: doc/BRIEF.md
# CPU Standby Mode Controller

This block decides when a CPU core enters and leaves its two low-power states, and it drives the clock gates for that core. The core sends a one-cycle strobe when it executes a wait-type or a stop-type instruction. The controller also watches the core's condition-code bits: the stop-disable bit S, the non-maskable mask X and the global maskable mask I. From these inputs it moves between running, a light sleep (WAIT) and a deep sleep (STOP). In WAIT only the CPU clock is gated. In STOP the CPU clock, the peripheral clock and the oscillator are all off, and the I/O pins are frozen.

The wake sources are an external maskable request line (active low, sensed by level or by a latched falling edge), a non-maskable external request line (active low), and a vector of internal peripheral requests. Each standby state has its own wake rules. When the core leaves standby, the controller gives a one-cycle wake event. A tag on that event tells the core whether it must take an interrupt or simply carry on after the standby instruction. Stacking and vector fetch belong to the core and are not part of this block. The controller runs on a free-running clock that is never gated.

Top module: `standby_ctrl`

## Requirements
- R1: While reset is held, and on the first cycle after it, the state is running: `cpu_clk_en`, `periph_clk_en` and `osc_en` are 1, `io_hold` is 0 and `wake_valid` is 0.
- R2: In the running state, a `wait_req` strobe with no effective stop request enters WAIT from the next cycle. In WAIT, `cpu_clk_en` is 0 while `periph_clk_en` and `osc_en` stay 1.
- R3: WAIT ends at the first clock edge where any of these is true: an unmasked maskable request (`irq_n` low in level mode, or a latched fall in edge mode, with I = 0), an unmasked peripheral request (any `periph_irq` bit = 1 with I = 0), or `xirq_n` low with X = 0. On the cycle after that edge, `cpu_clk_en` = 1, `wake_valid` = 1 and `wake_service` = 1. There is no restart delay.
- R4: While I = 1, `irq_n` and `periph_irq` do not end WAIT.
- R5: In the running state, a `stop_req` strobe with S = 0 enters STOP. In STOP, `cpu_clk_en`, `periph_clk_en` and `osc_en` are 0 and `io_hold` is 1.
- R6: STOP is not ended by `periph_irq`, nor by `irq_n` held low while `irq_edge_mode` = 0.
- R7: With `irq_edge_mode` = 1 and I = 0, a falling edge on `irq_n` is latched and ends STOP. The wake event then carries `wake_service` = 1.
- R8: `xirq_n` low always ends STOP. `wake_service` is 1 when X = 0 and 0 when X = 1, so with X = 1 execution resumes without an interrupt.
- R9: When STOP ends, `osc_en` goes to 1 at once. The CPU and peripheral clocks stay gated (and `io_hold` stays 1) for exactly RESTART_CYCLES cycles (16 by default). After that, both clocks return on the same cycle as `wake_valid`.
- R10: A `stop_req` strobe while S = 1 is a no-op: the block stays in the running state with all clocks enabled.
- R11: If `stop_req` and `wait_req` are both set in the same cycle, STOP wins when S = 0. When S = 1, the block enters WAIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wait_req | input | 1 | One-cycle strobe from a wait-type instruction |
| stop_req | input | 1 | One-cycle strobe from a stop-type instruction |
| s_bit | input | 1 | Stop-disable bit from the condition codes |
| x_bit | input | 1 | Non-maskable request mask bit |
| i_bit | input | 1 | Global maskable interrupt mask bit |
| irq_n | input | 1 | External maskable request, active low |
| irq_edge_mode | input | 1 | 1: falling edge of `irq_n` is latched; 0: low level is sensed |
| xirq_n | input | 1 | External non-maskable request, active low |
| periph_irq | input | NUM_PERIPH | Internal peripheral requests, active high (already locally enabled) |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| periph_clk_en | output | 1 | Peripheral clock gate enable |
| osc_en | output | 1 | Oscillator enable |
| io_hold | output | 1 | Freezes I/O pin levels |
| wake_valid | output | 1 | One-cycle wake event |
| wake_service | output | 1 | With `wake_valid`: 1 = take the interrupt, 0 = resume after the instruction |

## Verification
A wrong state shows at the clock-gate outputs on the very next cycle, because each of the four states has a distinct gate pattern. A wrong restart count changes the measured span between `osc_en` rising and `cpu_clk_en` rising. A dropped or phantom edge latch shows up as STOP either never ending or ending without an edge. A wrong mask combination shows up either as `wake_service` taking the wrong value on the wake cycle, or as a WAIT or STOP that persists through tens of cycles of a request that should have ended it.

// File: rtl/standby_pkg.sv
package standby_pkg;
  typedef enum logic [1:0] {
    SB_RUN     = 2'd0,
    SB_WAIT    = 2'd1,
    SB_STOP    = 2'd2,
    SB_RESTART = 2'd3
  } sb_state_e;
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_n,
  input  logic edge_mode,
  input  logic clr,
  output logic pend
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      pend   <= 1'b0;
    end else begin
      prev_q <= irq_n;
      if (!edge_mode || clr) pend <= 1'b0;
      else if (prev_q && !irq_n) pend <= 1'b1;
    end
  end

  // R7
  edge_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(irq_n) && edge_mode && !clr) |=> pend);
endmodule

// File: rtl/wake_logic.sv
module wake_logic #(
  parameter int NUM_PERIPH = 8
) (
  input  logic                  irq_n,
  input  logic                  edge_mode,
  input  logic                  edge_pend,
  input  logic                  xirq_n,
  input  logic [NUM_PERIPH-1:0] periph_irq,
  input  logic                  x_bit,
  input  logic                  i_bit,
  output logic                  wake_wait,
  output logic                  wake_stop,
  output logic                  svc_stop
);
  logic irq_req, maskable_live, xirq_live, irq_stop;

  always_comb begin
    irq_req       = edge_mode ? edge_pend : ~irq_n;
    maskable_live = (irq_req | (|periph_irq)) & ~i_bit;
    xirq_live     = ~xirq_n & ~x_bit;
    irq_stop      = edge_mode & edge_pend & ~i_bit;
    wake_wait     = maskable_live | xirq_live;
    wake_stop     = ~xirq_n | irq_stop;
    svc_stop      = xirq_live | irq_stop;
  end
endmodule

// File: rtl/standby_fsm.sv
module standby_fsm
  import standby_pkg::*;
#(
  parameter int RESTART_CYCLES = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wait_req,
  input  logic      stop_req,
  input  logic      s_bit,
  input  logic      wake_wait,
  input  logic      wake_stop,
  input  logic      svc_stop,
  output sb_state_e state,
  output logic      wake_taken,
  output logic      wake_valid,
  output logic      wake_service
);
  localparam int CNT_W = $clog2(RESTART_CYCLES + 1);

  sb_state_e        nxt;
  logic [CNT_W-1:0] cnt_q;
  logic             svc_q;
  logic             restart_done;

  assign restart_done = (state == SB_RESTART) && (cnt_q == '0);

  always_comb begin
    nxt        = state;
    wake_taken = 1'b0;
    case (state)
      SB_RUN: begin
        if (stop_req && !s_bit) nxt = SB_STOP;
        else if (wait_req)      nxt = SB_WAIT;
      end
      SB_WAIT: if (wake_wait) begin
        nxt        = SB_RUN;
        wake_taken = 1'b1;
      end
      SB_STOP: if (wake_stop) begin
        nxt        = SB_RESTART;
        wake_taken = 1'b1;
      end
      default: if (cnt_q == '0) nxt = SB_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= SB_RUN;
      cnt_q        <= '0;
      svc_q        <= 1'b0;
      wake_valid   <= 1'b0;
      wake_service <= 1'b0;
    end else begin
      state        <= nxt;
      wake_valid   <= ((state == SB_WAIT) && wake_wait) || restart_done;
      wake_service <= ((state == SB_WAIT) && wake_wait) || (restart_done && svc_q);
      if ((state == SB_STOP) && wake_stop) begin
        cnt_q <= CNT_W'(RESTART_CYCLES - 1);
        svc_q <= svc_stop;
      end else if ((state == SB_RESTART) && (cnt_q != '0)) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // R10
  stop_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SB_RUN && stop_req && s_bit && !wait_req) |=> (state == SB_RUN));
  // R6
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SB_STOP && !wake_stop) |=> (state == SB_STOP));
  // R9
  restart_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SB_RESTART && cnt_q != '0) |=> (state == SB_RESTART && !wake_valid));
  // R3
  wait_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SB_WAIT && wake_wait) |=> (state == SB_RUN && wake_valid && wake_service));
endmodule

// File: rtl/standby_ctrl.sv
module standby_ctrl
  import standby_pkg::*;
#(
  parameter int NUM_PERIPH     = 8,
  parameter int RESTART_CYCLES = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wait_req,
  input  logic                  stop_req,
  input  logic                  s_bit,
  input  logic                  x_bit,
  input  logic                  i_bit,
  input  logic                  irq_n,
  input  logic                  irq_edge_mode,
  input  logic                  xirq_n,
  input  logic [NUM_PERIPH-1:0] periph_irq,
  output logic                  cpu_clk_en,
  output logic                  periph_clk_en,
  output logic                  osc_en,
  output logic                  io_hold,
  output logic                  wake_valid,
  output logic                  wake_service
);
  sb_state_e state;
  logic edge_pend, edge_clr, wake_taken;
  logic wake_wait, wake_stop, svc_stop;

  // A latched edge is consumed only when the wake will be serviced as a maskable interrupt.
  assign edge_clr = wake_taken & ~i_bit;

  irq_edge_latch u_edge (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .edge_mode(irq_edge_mode),
    .clr(edge_clr), .pend(edge_pend)
  );

  wake_logic #(.NUM_PERIPH(NUM_PERIPH)) u_wake (
    .irq_n(irq_n), .edge_mode(irq_edge_mode), .edge_pend(edge_pend),
    .xirq_n(xirq_n), .periph_irq(periph_irq), .x_bit(x_bit), .i_bit(i_bit),
    .wake_wait(wake_wait), .wake_stop(wake_stop), .svc_stop(svc_stop)
  );

  standby_fsm #(.RESTART_CYCLES(RESTART_CYCLES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .wait_req(wait_req), .stop_req(stop_req),
    .s_bit(s_bit), .wake_wait(wake_wait), .wake_stop(wake_stop),
    .svc_stop(svc_stop), .state(state), .wake_taken(wake_taken),
    .wake_valid(wake_valid), .wake_service(wake_service)
  );

  always_comb begin
    cpu_clk_en    = 1'b0;
    periph_clk_en = 1'b0;
    osc_en        = 1'b0;
    io_hold       = 1'b0;
    case (state)
      SB_RUN:     begin cpu_clk_en = 1'b1; periph_clk_en = 1'b1; osc_en = 1'b1; end
      SB_WAIT:    begin periph_clk_en = 1'b1; osc_en = 1'b1; end
      SB_STOP:    io_hold = 1'b1;
      default:    begin osc_en = 1'b1; io_hold = 1'b1; end
    endcase
  end

  // R5
  stop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_hold && !osc_en) |-> (!cpu_clk_en && !periph_clk_en));
  // R9
  wake_clocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_valid |-> (cpu_clk_en && periph_clk_en && osc_en));
endmodule

// File: tb/standby_ctrl_test.sv
module standby_ctrl_test;
  localparam int NP = 8;
  localparam int RC = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wait_req = 0, stop_req = 0, s_bit = 0, x_bit = 0, i_bit = 0;
  logic irq_n = 1, irq_edge_mode = 0, xirq_n = 1;
  logic [NP-1:0] periph_irq = '0;
  logic cpu_clk_en, periph_clk_en, osc_en, io_hold, wake_valid, wake_service;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  standby_ctrl #(.NUM_PERIPH(NP), .RESTART_CYCLES(RC)) uut (
    .clk(clk), .rst_n(rst_n), .wait_req(wait_req), .stop_req(stop_req),
    .s_bit(s_bit), .x_bit(x_bit), .i_bit(i_bit), .irq_n(irq_n),
    .irq_edge_mode(irq_edge_mode), .xirq_n(xirq_n), .periph_irq(periph_irq),
    .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .osc_en(osc_en),
    .io_hold(io_hold), .wake_valid(wake_valid), .wake_service(wake_service)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // gates packed as {cpu, periph, osc, hold}
  function automatic int gates();
    return {28'd0, cpu_clk_en, periph_clk_en, osc_en, io_hold};
  endfunction

  task automatic strobe(input logic w, input logic s);
    wait_req = w; stop_req = s;
    step(1);
    wait_req = 0; stop_req = 0;
  endtask

  task automatic restart_seq(input string tag, input int exp_svc);
    int span = 0;
    for (int k = 0; k < 6 && !osc_en; k++) step(1);
    chk({tag, " osc on"}, osc_en, 1);
    while (!cpu_clk_en && span < 40) begin
      if (periph_clk_en || !io_hold) span = 100;
      span++;
      step(1);
    end
    chk({tag, " R9 gated span"}, span, RC);
    chk({tag, " R9 wake_valid"}, wake_valid, 1);
    chk({tag, " service"}, wake_service, exp_svc);
    chk({tag, " R9 clocks back"}, gates(), 4'b1110);
  endtask

  task automatic t_reset();
    step(1);
    chk("R1 gates in reset", gates(), 4'b1110);
    rst_n = 1;
    step(1);
    chk("R1 gates after reset", gates(), 4'b1110);
    chk("R1 wake_valid", wake_valid, 0);
  endtask

  task automatic t_wait_level_irq();
    strobe(1, 0);
    chk("R2 wait gates", gates(), 4'b0110);
    step(3);
    chk("R2 wait persists", gates(), 4'b0110);
    irq_n = 0;
    step(1);
    chk("R3 level irq wake_valid", wake_valid, 1);
    chk("R3 level irq service", wake_service, 1);
    chk("R3 no delay cpu on", cpu_clk_en, 1);
    irq_n = 1;
    step(1);
    chk("R3 wake pulse one cycle", wake_valid, 0);
  endtask

  task automatic t_wait_masked();
    i_bit = 1;
    strobe(1, 0);
    periph_irq = 8'h10;
    irq_n = 0;
    step(20);
    chk("R4 masked stays wait", gates(), 4'b0110);
    irq_n = 1;
    i_bit = 0;
    step(1);
    chk("R3 periph wake_valid", wake_valid, 1);
    chk("R3 periph service", wake_service, 1);
    periph_irq = '0;
    step(1);
  endtask

  task automatic t_wait_xirq();
    x_bit = 0; i_bit = 1;
    strobe(1, 0);
    xirq_n = 0;
    step(1);
    chk("R3 xirq wait wake", wake_valid, 1);
    chk("R3 xirq wait cpu", cpu_clk_en, 1);
    xirq_n = 1; i_bit = 0;
    step(1);
  endtask

  task automatic t_stop_no_wake();
    irq_edge_mode = 0;
    strobe(0, 1);
    chk("R5 stop gates", gates(), 4'b0001);
    periph_irq = 8'hFF;
    irq_n = 0;
    step(30);
    chk("R6 periph and level irq ignored", gates(), 4'b0001);
    chk("R6 no wake", wake_valid, 0);
    periph_irq = '0;
    irq_n = 1;
    step(2);
    x_bit = 0;
    xirq_n = 0;
    restart_seq("R8 xirq x clear", 1);
    xirq_n = 1;
    step(2);
  endtask

  task automatic t_stop_xirq_masked();
    x_bit = 1;
    strobe(0, 1);
    chk("R5 stop again", gates(), 4'b0001);
    xirq_n = 0;
    restart_seq("R8 xirq x set", 0);
    xirq_n = 1; x_bit = 0;
    step(2);
  endtask

  task automatic t_stop_edge();
    irq_edge_mode = 1;
    step(2);
    strobe(0, 1);
    step(3);
    chk("R7 stop before edge", gates(), 4'b0001);
    irq_n = 0;
    restart_seq("R7 edge wake", 1);
    step(5);
    irq_n = 1;
    irq_edge_mode = 0;
    step(2);
  endtask

  task automatic t_s_bit();
    s_bit = 1;
    strobe(0, 1);
    chk("R10 stop ignored gates", gates(), 4'b1110);
    step(3);
    chk("R10 still running", gates(), 4'b1110);
    chk("R10 no wake", wake_valid, 0);
    strobe(1, 1);
    chk("R11 both with S set -> wait", gates(), 4'b0110);
    periph_irq = 8'h01;
    step(1);
    chk("R11 periph ends wait", wake_valid, 1);
    periph_irq = '0;
    s_bit = 0;
    step(1);
    strobe(1, 1);
    chk("R11 both with S clear -> stop", gates(), 4'b0001);
    xirq_n = 0;
    restart_seq("R11 exit", 1);
    xirq_n = 1;
    step(2);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_wait_level_irq();
    t_wait_masked();
    t_wait_xirq();
    t_stop_no_wake();
    t_stop_xirq_masked();
    t_stop_edge();
    t_s_bit();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule